// File: doc/BRIEF.md
# Dirty Scanline Run Coalescer

This block turns per-row dirty information into a short list of rectangular refresh requests. It is given a frame command that holds the surface height, the surface width and a full-refresh flag. It then visits the rows from the top of the surface downward, one row per cycle. For each row it asks an external dirty-row source whether that row changed. Any run of adjacent changed rows becomes one rectangle that starts at column 0 and covers the full surface width.

When the command asks for a full refresh, the block skips the scan entirely and issues one rectangle that covers the whole surface. When a scan begins, the block pulses a snapshot strobe. The dirty source uses this strobe to capture its bits for the frame and clear them for the next frame. Rectangles leave through a valid/ready port. A frame-complete pulse marks the point at which every rectangle of the frame has been handed over.

Top module: `scanline_span_merger`

## Requirements
- R1: A command with the full flag set yields exactly one rectangle, with start row 0 and a row count equal to the height. No row is probed and no snapshot strobe is raised.
- R2: During a scan, the row index presented with `row_probe` takes each value from 0 to height-1 exactly once, in increasing order.
- R3: A run opens at the first dirty row seen while no run is open. The rectangle for that run carries this row as its start row.
- R4: An open run closes at the first clean row. Its rectangle carries a row count equal to the clean row's index minus the start row.
- R5: If a run is still open when the last row has been probed, its rectangle is issued with a count equal to the height minus its start row.
- R6: Every rectangle reports column 0 and a width equal to the width given with the command.
- R7: `snap_take` is high for exactly one cycle, in the cycle the command is accepted, and only for a command that starts a scan: full flag clear and height nonzero.
- R8: While `upd_valid` is high and `upd_ready` is low, the rectangle outputs hold their values and no row is probed.
- R9: `frame_done` pulses for one cycle after the last row has been handled and the last rectangle has been accepted. `start_ready` is low from the cycle after acceptance until that pulse.
- R10: A command with height 0 and the full flag clear produces no rectangle, no probe and no snapshot, and still ends with `frame_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_valid | input | 1 | Frame command present |
| start_ready | output | 1 | Block idle, command accepted when valid |
| start_full | input | 1 | Request a whole-surface refresh |
| start_height | input | HW | Surface height in rows |
| start_width | input | HW | Surface width in pixels |
| snap_take | output | 1 | Capture-and-clear strobe for the dirty source |
| row_probe | output | 1 | A row is examined this cycle |
| row_idx | output | HW | Row being examined |
| row_dirty | input | 1 | Dirty bit of `row_idx`, answered in the same cycle |
| upd_valid | output | 1 | Rectangle available |
| upd_ready | input | 1 | Consumer takes the rectangle |
| upd_x | output | HW | Left column (always 0) |
| upd_y | output | HW | First row of the rectangle |
| upd_width | output | HW | Rectangle width |
| upd_rows | output | HW | Number of rows in the rectangle |
| frame_done | output | 1 | One-cycle end-of-frame pulse |

## Verification
The bench goes after runs that touch the first or the last row, single-row runs that alternate with clean rows, a single one-row surface, and a fully dirty surface. A design that mishandles the end of the frame would drop the trailing run or miscount it. A design with an off-by-one close would report runs one row too long. The bench also holds the consumer back while a rectangle is pending. A design that kept probing in that state would lose or overwrite rectangles, and a design that let its outputs drift would corrupt them. Full-refresh and zero-height commands check that the scan and the snapshot are skipped and that the frame still completes.

// File: rtl/span_pkg.sv
package span_pkg;
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SCAN  = 2'd1,
        PH_DRAIN = 2'd2
    } phase_e;
endpackage

// File: rtl/span_ctrl.sv
module span_ctrl
    import span_pkg::*;
#(
    parameter int HW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_valid,
    input  logic          start_full,
    input  logic [HW-1:0] start_height,
    input  logic [HW-1:0] start_width,
    input  logic          slot_busy,
    input  logic          slot_taken,
    output logic          start_ready,
    output logic          snap,
    output logic          clear,
    output logic          full_load,
    output logic          step,
    output logic [HW-1:0] row_idx,
    output logic          last_row,
    output logic [HW-1:0] height,
    output logic [HW-1:0] width,
    output logic          done
);
    typedef struct packed {
        phase_e        phase;
        logic [HW-1:0] row;
        logic [HW-1:0] height;
        logic [HW-1:0] width;
        logic          done;
    } ctrl_t;

    ctrl_t s_d, s_q;
    logic  slot_free;
    logic  accept;

    assign slot_free = !slot_busy || slot_taken;

    always_comb begin
        s_d       = s_q;
        s_d.done  = 1'b0;
        accept    = 1'b0;
        snap      = 1'b0;
        full_load = 1'b0;
        step      = 1'b0;
        last_row  = (s_q.row == s_q.height - 1'b1);
        unique case (s_q.phase)
            PH_IDLE: begin
                if (start_valid) begin
                    accept     = 1'b1;
                    s_d.height = start_height;
                    s_d.width  = start_width;
                    s_d.row    = '0;
                    if (start_full) begin
                        full_load = 1'b1;
                        s_d.phase = PH_DRAIN;
                    end else if (start_height == '0) begin
                        s_d.phase = PH_DRAIN;
                    end else begin
                        snap      = 1'b1;
                        s_d.phase = PH_SCAN;
                    end
                end
            end
            PH_SCAN: begin
                if (slot_free) begin
                    step    = 1'b1;
                    s_d.row = s_q.row + 1'b1;
                    if (last_row) s_d.phase = PH_DRAIN;
                end
            end
            PH_DRAIN: begin
                if (slot_free) begin
                    s_d.done  = 1'b1;
                    s_d.phase = PH_IDLE;
                end
            end
            default: s_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{phase: PH_IDLE, row: '0, height: '0, width: '0, done: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign start_ready = (s_q.phase == PH_IDLE);
    assign clear       = accept;
    assign row_idx     = s_q.row;
    assign height      = s_q.height;
    assign width       = s_q.width;
    assign done        = s_q.done;

    // R2: a probed row lies inside the surface
    p_probe_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (s_q.row < s_q.height));

    // R2: rows advance by one after each probe that is not the last
    p_row_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !last_row) |=> (s_q.row == $past(s_q.row) + 1'b1));

    // R9: a command is never taken while a frame is in progress
    p_no_accept_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase != PH_IDLE) |=> !$rose(s_q.phase == PH_SCAN) || $past(accept));
endmodule

// File: rtl/span_track.sv
module span_track #(
    parameter int HW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          step,
    input  logic [HW-1:0] row,
    input  logic          dirty,
    input  logic          last,
    input  logic [HW-1:0] height,
    output logic          emit,
    output logic [HW-1:0] emit_y,
    output logic [HW-1:0] emit_rows
);
    typedef struct packed {
        logic          open;
        logic [HW-1:0] first;
    } run_t;

    run_t r_d, r_q;

    always_comb begin
        r_d       = r_q;
        emit      = 1'b0;
        emit_y    = r_q.first;
        emit_rows = '0;
        if (clear) begin
            r_d.open  = 1'b0;
            r_d.first = '0;
        end else if (step) begin
            if (dirty) begin
                if (!r_q.open) begin
                    r_d.open  = 1'b1;
                    r_d.first = row;
                end
                if (last) begin
                    emit      = 1'b1;
                    emit_y    = r_q.open ? r_q.first : row;
                    emit_rows = height - emit_y;
                    r_d.open  = 1'b0;
                end
            end else if (r_q.open) begin
                emit      = 1'b1;
                emit_y    = r_q.first;
                emit_rows = row - r_q.first;
                r_d.open  = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{open: 1'b0, first: '0};
        end else begin
            r_q <= r_d;
        end
    end

    // R3: an open run never starts after the row being probed
    p_run_before_row_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && r_q.open) |-> (r_q.first < row));

    // R5: after the last probe no run is left open
    p_closed_at_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (step && last) |=> !r_q.open);
endmodule

// File: rtl/update_slot.sv
module update_slot #(
    parameter int HW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [HW-1:0] load_y,
    input  logic [HW-1:0] load_rows,
    input  logic          ready,
    output logic          valid,
    output logic [HW-1:0] y,
    output logic [HW-1:0] rows
);
    typedef struct packed {
        logic          valid;
        logic [HW-1:0] y;
        logic [HW-1:0] rows;
    } slot_t;

    slot_t o_d, o_q;

    always_comb begin
        o_d = o_q;
        if (load) begin
            o_d.valid = 1'b1;
            o_d.y     = load_y;
            o_d.rows  = load_rows;
        end else if (o_q.valid && ready) begin
            o_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_q <= '{valid: 1'b0, y: '0, rows: '0};
        end else begin
            o_q <= o_d;
        end
    end

    assign valid = o_q.valid;
    assign y     = o_q.y;
    assign rows  = o_q.rows;

    // R8: a pending rectangle is never overwritten
    p_load_when_free_r8: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (!o_q.valid || ready));

    // R8: a stalled rectangle keeps its contents
    p_hold_while_stalled_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (o_q.valid && !ready) |=> (o_q.valid && $stable(o_q.y) && $stable(o_q.rows)));
endmodule

// File: rtl/scanline_span_merger.sv
module scanline_span_merger #(
    parameter int HW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_valid,
    output logic          start_ready,
    input  logic          start_full,
    input  logic [HW-1:0] start_height,
    input  logic [HW-1:0] start_width,
    output logic          snap_take,
    output logic          row_probe,
    output logic [HW-1:0] row_idx,
    input  logic          row_dirty,
    output logic          upd_valid,
    input  logic          upd_ready,
    output logic [HW-1:0] upd_x,
    output logic [HW-1:0] upd_y,
    output logic [HW-1:0] upd_width,
    output logic [HW-1:0] upd_rows,
    output logic          frame_done
);
    logic          clear, full_load, step, last_row;
    logic [HW-1:0] height, width;
    logic          emit;
    logic [HW-1:0] emit_y, emit_rows;
    logic          load;
    logic [HW-1:0] load_y, load_rows;

    span_ctrl #(.HW(HW)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_valid  (start_valid),
        .start_full   (start_full),
        .start_height (start_height),
        .start_width  (start_width),
        .slot_busy    (upd_valid),
        .slot_taken   (upd_ready),
        .start_ready  (start_ready),
        .snap         (snap_take),
        .clear        (clear),
        .full_load    (full_load),
        .step         (step),
        .row_idx      (row_idx),
        .last_row     (last_row),
        .height       (height),
        .width        (width),
        .done         (frame_done)
    );

    span_track #(.HW(HW)) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clear),
        .step      (step),
        .row       (row_idx),
        .dirty     (row_dirty),
        .last      (last_row),
        .height    (height),
        .emit      (emit),
        .emit_y    (emit_y),
        .emit_rows (emit_rows)
    );

    always_comb begin
        load      = full_load | emit;
        load_y    = full_load ? '0 : emit_y;
        load_rows = full_load ? start_height : emit_rows;
    end

    update_slot #(.HW(HW)) u_slot (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_y    (load_y),
        .load_rows (load_rows),
        .ready     (upd_ready),
        .valid     (upd_valid),
        .y         (upd_y),
        .rows      (upd_rows)
    );

    assign row_probe = step;
    assign upd_x     = '0;
    assign upd_width = width;

    // R8: no probe while the consumer holds back a rectangle
    p_probe_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !upd_ready) |-> !row_probe);

    // R4: every issued rectangle is non-empty and stays inside the surface
    p_rect_inside_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !start_ready) |-> ((upd_rows != '0) && ({1'b0, upd_y} + {1'b0, upd_rows} <= {1'b0, height})));

    // R9: the frame ends only with the output slot empty
    p_done_slot_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> !upd_valid);

    // R7: the snapshot strobe is only raised when a command is being taken
    p_snap_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        snap_take |-> (start_ready && start_valid && !start_full));
endmodule

// File: tb/tb_scanline_span_merger.sv
module tb_scanline_span_merger;
    localparam int HW = 12;

    typedef struct packed {
        logic [6:0]  h;
        logic        full;
        logic [63:0] mask;
        logic [1:0]  stall;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{h: 7'd8,  full: 1'b0, mask: 64'h0,                  stall: 2'd0},
        '{h: 7'd8,  full: 1'b0, mask: 64'hFF,                 stall: 2'd0},
        '{h: 7'd10, full: 1'b0, mask: 64'h036,                stall: 2'd1},
        '{h: 7'd16, full: 1'b0, mask: 64'h5555,               stall: 2'd1},
        '{h: 7'd12, full: 1'b1, mask: 64'hF0F0,               stall: 2'd2},
        '{h: 7'd1,  full: 1'b0, mask: 64'h1,                  stall: 2'd0},
        '{h: 7'd64, full: 1'b0, mask: 64'h8000_0000_0000_0001, stall: 2'd2},
        '{h: 7'd5,  full: 1'b0, mask: 64'h1E,                 stall: 2'd2}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_valid = 1'b0;
    logic          start_ready;
    logic          start_full = 1'b0;
    logic [HW-1:0] start_height = '0;
    logic [HW-1:0] start_width = '0;
    logic          snap_take;
    logic          row_probe;
    logic [HW-1:0] row_idx;
    logic          row_dirty;
    logic          upd_valid;
    logic          upd_ready = 1'b1;
    logic [HW-1:0] upd_x, upd_y, upd_width, upd_rows;
    logic          frame_done;

    logic [63:0] mask = '0;
    logic [1:0]  stall_mode = '0;
    logic        hold_low = 1'b0;
    int          cyc = 0;
    int          checks = 0;
    int          errors = 0;

    int cap_n, probe_n, snap_n, done_n, exp_row, probe_bad, col_bad, done_bad;
    int cap_y [64];
    int cap_r [64];
    int exp_n;
    int exp_y [64];
    int exp_r [64];
    logic [HW-1:0] cur_width;

    always #10 clk = ~clk;

    assign row_dirty = mask[row_idx[5:0]];

    scanline_span_merger #(.HW(HW)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_valid  (start_valid),
        .start_ready  (start_ready),
        .start_full   (start_full),
        .start_height (start_height),
        .start_width  (start_width),
        .snap_take    (snap_take),
        .row_probe    (row_probe),
        .row_idx      (row_idx),
        .row_dirty    (row_dirty),
        .upd_valid    (upd_valid),
        .upd_ready    (upd_ready),
        .upd_x        (upd_x),
        .upd_y        (upd_y),
        .upd_width    (upd_width),
        .upd_rows     (upd_rows),
        .frame_done   (frame_done)
    );

    always @(posedge clk) begin
        #1;
        cyc = cyc + 1;
        if (hold_low)             upd_ready = 1'b0;
        else if (stall_mode == 0) upd_ready = 1'b1;
        else if (stall_mode == 1) upd_ready = (cyc % 3) != 0;
        else                      upd_ready = (cyc % 4) == 0;
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (row_probe) begin
                if (row_idx != HW'(exp_row)) probe_bad = probe_bad + 1;
                exp_row = exp_row + 1;
                probe_n = probe_n + 1;
            end
            if (snap_take) snap_n = snap_n + 1;
            if (upd_valid && upd_ready) begin
                if (cap_n < 64) begin
                    cap_y[cap_n] = int'(upd_y);
                    cap_r[cap_n] = int'(upd_rows);
                end
                cap_n = cap_n + 1;
                if (upd_x != '0 || upd_width != cur_width) col_bad = col_bad + 1;
            end
            if (frame_done) begin
                done_n = done_n + 1;
                if (upd_valid) done_bad = done_bad + 1;
            end
        end
    end

    always @(posedge clk) begin
        if (cyc > 100000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d cycles expected < 100000", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_mon();
        cap_n = 0; probe_n = 0; snap_n = 0; done_n = 0; exp_row = 0;
        probe_bad = 0; col_bad = 0; done_bad = 0;
    endtask

    task automatic build_expect(input int h, input logic full, input logic [63:0] m);
        int first;
        exp_n = 0;
        first = -1;
        if (full) begin
            exp_y[0] = 0; exp_r[0] = h; exp_n = 1;
        end else begin
            for (int r = 0; r < h; r++) begin
                if (m[r] && first < 0) first = r;
                if (!m[r] && first >= 0) begin
                    exp_y[exp_n] = first; exp_r[exp_n] = r - first;
                    exp_n = exp_n + 1; first = -1;
                end
            end
            if (first >= 0) begin
                exp_y[exp_n] = first; exp_r[exp_n] = h - first;
                exp_n = exp_n + 1;
            end
        end
    endtask

    task automatic issue(input int h, input logic full, input int w);
        @(posedge clk); #2;
        start_valid  = 1'b1;
        start_full   = full;
        start_height = HW'(h);
        start_width  = HW'(w);
        cur_width    = HW'(w);
        @(posedge clk); #2;
        start_valid  = 1'b0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 2000; i++) begin
            if (done_n > 0) break;
            @(posedge clk); #2;
        end
        repeat (3) @(posedge clk);
        #2;
    endtask

    task automatic compare_spans(input string tag);
        check({tag, " R3 R4 R5 rectangle count"}, cap_n, exp_n);
        for (int k = 0; k < exp_n && k < cap_n; k++) begin
            check({tag, " R3 start row"}, cap_y[k], exp_y[k]);
            check({tag, " R4 R5 row count"}, cap_r[k], exp_r[k]);
        end
    endtask

    initial begin
        clear_mon();
        cur_width = '0;
        repeat (3) @(posedge clk);
        #2;
        check("reset upd_valid", int'(upd_valid), 0);
        check("reset R9 start_ready", int'(start_ready), 1);
        check("reset R9 frame_done", int'(frame_done), 0);
        check("reset R2 row_probe", int'(row_probe), 0);
        rst_n = 1'b1;
        @(posedge clk); #2;

        for (int v = 0; v < NV; v++) begin
            clear_mon();
            mask       = VECS[v].mask;
            stall_mode = VECS[v].stall;
            build_expect(int'(VECS[v].h), VECS[v].full, VECS[v].mask);
            issue(int'(VECS[v].h), VECS[v].full, 100 + v);
            wait_done();
            compare_spans($sformatf("vec%0d", v));
            check("R2 probe count", probe_n, VECS[v].full ? 0 : int'(VECS[v].h));
            check("R2 probe order", probe_bad, 0);
            check("R7 snapshot count", snap_n, VECS[v].full ? 0 : 1);
            check("R6 column and width", col_bad, 0);
            check("R9 single done", done_n, 1);
            check("R9 done after drain", done_bad, 0);
            if (VECS[v].full) check("R1 full refresh no probe", probe_n, 0);
        end

        // R10: empty surface
        clear_mon();
        stall_mode = 0;
        mask = 64'hFFFF;
        build_expect(0, 1'b0, mask);
        issue(0, 1'b0, 77);
        wait_done();
        check("R10 no rectangle", cap_n, 0);
        check("R10 no probe", probe_n, 0);
        check("R10 no snapshot", snap_n, 0);
        check("R10 done", done_n, 1);

        // R8 / R9: consumer held back
        clear_mon();
        hold_low = 1'b1;
        mask = 64'h5;
        build_expect(4, 1'b0, mask);
        issue(4, 1'b0, 33);
        repeat (10) @(posedge clk);
        #2;
        check("R8 pending valid", int'(upd_valid), 1);
        check("R8 pending start row", int'(upd_y), 0);
        check("R8 pending rows", int'(upd_rows), 1);
        check("R8 probes stalled", probe_n, 2);
        check("R9 busy start_ready", int'(start_ready), 0);
        check("R9 no early done", done_n, 0);
        @(posedge clk); #2;
        check("R8 still held", int'(upd_y) * 16 + int'(upd_rows), 1);
        hold_low = 1'b0;
        wait_done();
        compare_spans("stall");
        check("R9 done after stall", done_n, 1);
        check("R9 idle again", int'(start_ready), 1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule